// File: doc/BRIEF.md
# Program Status Word Controller

This block keeps the processor's live status word and one saved status word for each exception bank that owns one. A move-to-status operation presents a data word, a four-bit field mask, a target select (live word or the saved word of the present bank) and the code of the bank the processor runs in. The block merges the data into the addressed word. How much of the word may change depends on privilege and on the mask. A separate read port returns any bank's saved word by combinational lookup.

Every write to the live word compares the new mode field with the old one. When the two differ, the block raises a one-cycle strobe so that the register file can swap its banked registers. The block also arbitrates the three active-low exception lines against the interrupt-disable bits of the held status word. It registers the winner as a one-hot vector select.

Top module: `psw_ctrl`

## Requirements
- R1: With `cur_bank` = 0 (user), a write to the live word loads bits 31:24 from `wr_data` and keeps bits 23:0, whatever `field_mask` holds.
- R2: With any other `cur_bank`, a live write with `field_mask` = 4'd9 loads all 32 bits.
- R3: With any other `cur_bank` and any other mask value, `field_mask[0]` loads bits 7:0 and `field_mask[3]` loads bits 31:24. Bits 23:8 are kept, and `field_mask[1]` and `field_mask[2]` have no effect.
- R4: Only banks 1 to 5 own a saved word. A saved-target write applies the R2/R3 rule to the saved word of `cur_bank`, and is ignored for banks 0, 6 and 7. `saved_rd` returns the word of `rd_bank`, or zero for banks 0, 6 and 7.
- R5: `mode_chg` is high for exactly the one cycle after a live write whose resulting bits 4:0 differ from the bits 4:0 held before it. At all other times it is low.
- R6: `exc_sel` is registered one cycle after the lines are sampled, and uses one-hot codes. Bit 0 (reset) is chosen when `nrst_line` is low. Otherwise bit 1 (fast) is chosen when `nfiq_line` is low and status bit 6 is clear. Otherwise bit 2 (normal) is chosen when `nirq_line` is low and status bit 7 is clear. Otherwise the value is zero.
- R7: After reset, `psw` is 32'h0000_00D3, every saved word is zero, and `mode_chg` and `exc_sel` are zero.
- R8: A saved-target write never changes `psw`, and a live write never changes a saved word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_saved | input | 1 | 1 targets the saved word of `cur_bank`, 0 the live word |
| field_mask | input | 4 | Field select; bit 0 control byte, bit 3 flag byte, 9 = whole word |
| wr_data | input | 32 | Value to merge |
| cur_bank | input | 3 | Bank the processor runs in (0 user, 1..5 exception banks, 6 system, 7 none) |
| rd_bank | input | 3 | Bank whose saved word is read |
| nrst_line | input | 1 | Reset request, active low |
| nfiq_line | input | 1 | Fast interrupt request, active low |
| nirq_line | input | 1 | Normal interrupt request, active low |
| psw | output | 32 | Live status word |
| saved_rd | output | 32 | Saved word of `rd_bank`, or zero |
| mode_chg | output | 1 | One-cycle mode-change strobe |
| exc_sel | output | 3 | One-hot registered exception vector select |

## Verification
The bench sweeps every bank against every mask value, for both the live and the saved targets. A design that decoded the whole-word code wrongly would clear or keep the middle bytes. A design that honoured the mask in user mode would let the control byte change. The bench reads all eight banks back after it has written them, which catches a design that stores words for the user, system or unused banks. It also drives each combination of the three exception lines under each state of the two disable bits, which exposes swapped priority or a mask bit tied to the wrong line. The mode-change strobe is checked after every live write, including writes in user mode, where the mode field cannot change.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int WORD_W    = 32;
    localparam int BANK_W    = 3;
    localparam int FMASK_W   = 4;
    localparam int MODE_W    = 5;
    localparam int FBIT_POS  = 6;
    localparam int IBIT_POS  = 7;
    localparam int EXC_W     = 3;

    localparam logic [BANK_W-1:0]  BANK_USER  = 3'd0;
    localparam logic [FMASK_W-1:0] FMASK_FULL = 4'd9;

    typedef logic [EXC_W-1:0] exc_t;
    localparam exc_t EXC_NONE  = 3'b000;
    localparam exc_t EXC_RESET = 3'b001;
    localparam exc_t EXC_FAST  = 3'b010;
    localparam exc_t EXC_NORM  = 3'b100;
endpackage

// File: rtl/psw_field_merge.sv
module psw_field_merge
    import psw_pkg::*;
(
    input  logic [WORD_W-1:0]  old_word,
    input  logic [WORD_W-1:0]  new_data,
    input  logic [FMASK_W-1:0] mask,
    input  logic               flags_only,
    output logic [WORD_W-1:0]  merged
);
    localparam int CTRL_HI = 7;
    localparam int FLAG_LO = WORD_W - 8;

    always_comb begin
        merged = old_word;
        if (flags_only) begin
            merged[WORD_W-1:FLAG_LO] = new_data[WORD_W-1:FLAG_LO];
        end else if (mask == FMASK_FULL) begin
            merged = new_data;
        end else begin
            if (mask[0]) merged[CTRL_HI:0] = new_data[CTRL_HI:0];
            if (mask[FMASK_W-1]) merged[WORD_W-1:FLAG_LO] = new_data[WORD_W-1:FLAG_LO];
        end
    end
endmodule

// File: rtl/psw_exc_pick.sv
module psw_exc_pick
    import psw_pkg::*;
(
    input  logic rst_req,
    input  logic fiq_req,
    input  logic irq_req,
    input  logic fiq_off,
    input  logic irq_off,
    output exc_t pick
);
    always_comb begin
        if (rst_req)                 pick = EXC_RESET;
        else if (fiq_req && !fiq_off) pick = EXC_FAST;
        else if (irq_req && !irq_off) pick = EXC_NORM;
        else                          pick = EXC_NONE;
    end
endmodule

// File: rtl/psw_saved_file.sv
module psw_saved_file
    import psw_pkg::*;
#(
    parameter int FIRST_SAVED = 1,
    parameter int LAST_SAVED  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [BANK_W-1:0] rd_bank,
    output logic [WORD_W-1:0] wr_old,
    output logic [WORD_W-1:0] rd_word
);
    localparam int NUM_SAVED = LAST_SAVED - FIRST_SAVED + 1;

    logic [WORD_W-1:0] saved_q [NUM_SAVED];

    for (genvar g = 0; g < NUM_SAVED; g++) begin : g_entry
        localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(FIRST_SAVED + g);
        logic [WORD_W-1:0] word_d;

        always_comb begin
            word_d = saved_q[g];
            if (wr_en && (wr_bank == MY_BANK)) word_d = wr_word;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) saved_q[g] <= '0;
            else        saved_q[g] <= word_d;
        end
    end

    always_comb begin
        wr_old  = '0;
        rd_word = '0;
        for (int i = 0; i < NUM_SAVED; i++) begin
            if (wr_bank == BANK_W'(FIRST_SAVED + i)) wr_old  = saved_q[i];
            if (rd_bank == BANK_W'(FIRST_SAVED + i)) rd_word = saved_q[i];
        end
    end
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
    import psw_pkg::*;
#(
    parameter logic [31:0] RESET_WORD  = 32'h0000_00D3,
    parameter int          FIRST_SAVED = 1,
    parameter int          LAST_SAVED  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_saved,
    input  logic [3:0]  field_mask,
    input  logic [31:0] wr_data,
    input  logic [2:0]  cur_bank,
    input  logic [2:0]  rd_bank,
    input  logic        nrst_line,
    input  logic        nfiq_line,
    input  logic        nirq_line,
    output logic [31:0] psw,
    output logic [31:0] saved_rd,
    output logic        mode_chg,
    output logic [2:0]  exc_sel
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              chg;
        exc_t              exc;
    } state_t;

    state_t st_d, st_q;

    logic              live_wr, saved_wr, in_user;
    logic [WORD_W-1:0] live_merged, saved_merged, saved_old;
    exc_t              exc_pick;

    assign in_user  = (cur_bank == BANK_USER);
    assign live_wr  = wr_en && !wr_saved;
    assign saved_wr = wr_en && wr_saved;

    psw_field_merge u_live_merge (
        .old_word   (st_q.word),
        .new_data   (wr_data),
        .mask       (field_mask),
        .flags_only (in_user),
        .merged     (live_merged)
    );

    psw_field_merge u_saved_merge (
        .old_word   (saved_old),
        .new_data   (wr_data),
        .mask       (field_mask),
        .flags_only (1'b0),
        .merged     (saved_merged)
    );

    psw_saved_file #(
        .FIRST_SAVED (FIRST_SAVED),
        .LAST_SAVED  (LAST_SAVED)
    ) u_saved (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (saved_wr),
        .wr_bank (cur_bank),
        .wr_word (saved_merged),
        .rd_bank (rd_bank),
        .wr_old  (saved_old),
        .rd_word (saved_rd)
    );

    psw_exc_pick u_pick (
        .rst_req (!nrst_line),
        .fiq_req (!nfiq_line),
        .irq_req (!nirq_line),
        .fiq_off (st_q.word[FBIT_POS]),
        .irq_off (st_q.word[IBIT_POS]),
        .pick    (exc_pick)
    );

    always_comb begin
        st_d     = st_q;
        st_d.chg = 1'b0;
        st_d.exc = exc_pick;
        if (live_wr) begin
            st_d.word = live_merged;
            st_d.chg  = (live_merged[MODE_W-1:0] != st_q.word[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word <= RESET_WORD;
            st_q.chg  <= 1'b0;
            st_q.exc  <= EXC_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign psw      = st_q.word;
    assign mode_chg = st_q.chg;
    assign exc_sel  = st_q.exc;
endmodule

// File: rtl/psw_ctrl_chk.sv
module psw_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_saved,
    input logic [3:0]  field_mask,
    input logic [31:0] wr_data,
    input logic [2:0]  cur_bank,
    input logic [2:0]  rd_bank,
    input logic        nrst_line,
    input logic        nfiq_line,
    input logic        nirq_line,
    input logic [31:0] psw,
    input logic [31:0] saved_rd,
    input logic        mode_chg,
    input logic [2:0]  exc_sel
);
    p_user_flags_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_saved && cur_bank == 3'd0) |=>
        (psw[23:0] == $past(psw[23:0])) && (psw[31:24] == $past(wr_data[31:24])));

    p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_saved && cur_bank != 3'd0 && field_mask == 4'd9) |=>
        (psw == $past(wr_data)));

    p_mid_bytes_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_saved && cur_bank != 3'd0 && field_mask != 4'd9) |=>
        (psw[23:8] == $past(psw[23:8])));

    p_no_saved_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_bank == 3'd0 || rd_bank > 3'd5) |-> (saved_rd == 32'd0));

    p_chg_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |-> $past(wr_en && !wr_saved));

    p_exc_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(exc_sel));

    p_reset_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !nrst_line |=> (exc_sel == 3'b001));

    p_fast_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nrst_line && !nfiq_line && !psw[6]) |=> (exc_sel == 3'b010));

    p_norm_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (nrst_line && (nfiq_line || psw[6]) && !nirq_line && !psw[7]) |=>
        (exc_sel == 3'b100));

    p_saved_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_saved) |=> $stable(psw));
endmodule

bind psw_ctrl psw_ctrl_chk u_chk (.*);

// File: tb/sim_psw_ctrl.sv
`timescale 1ns/1ps
module sim_psw_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_saved = 1'b0;
    logic [3:0]  field_mask = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  cur_bank = '0, rd_bank = '0;
    logic        nrst_line = 1'b1, nfiq_line = 1'b1, nirq_line = 1'b1;
    logic [31:0] psw, saved_rd;
    logic        mode_chg;
    logic [2:0]  exc_sel;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_psw;
    logic [31:0] m_saved [8];

    always #2 clk = ~clk;

    psw_ctrl u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d,
                                          input logic [3:0] m, input logic user);
        logic [31:0] r = o;
        if (user) r[31:24] = d[31:24];
        else if (m == 4'd9) r = d;
        else begin
            if (m[0]) r[7:0] = d[7:0];
            if (m[3]) r[31:24] = d[31:24];
        end
        return r;
    endfunction

    task automatic do_wr(input logic sv, input logic [2:0] b, input logic [3:0] m,
                         input logic [31:0] d);
        wr_saved = sv; cur_bank = b; field_mask = m; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] pat(input int b, input int m);
        return {8'(b * 29 + m * 3 + 1), 8'(m * 17 + 5), 8'(b * 5 + m), 8'(b * 11 + m * 7 + 3)};
    endfunction

    function automatic logic [2:0] exp_exc(input logic [2:0] l, input logic [1:0] fm);
        if (!l[0]) return 3'b001;
        if (!l[1] && !fm[0]) return 3'b010;
        if (!l[2] && !fm[1]) return 3'b100;
        return 3'b000;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        m_psw = 32'h0000_00D3;
        for (int i = 0; i < 8; i++) m_saved[i] = '0;
        chk("R7 psw", psw, m_psw);
        chk("R7 mode_chg", {31'd0, mode_chg}, 32'd0);
        chk("R7 exc_sel", {29'd0, exc_sel}, 32'd0);
        for (int i = 0; i < 8; i++) begin
            rd_bank = 3'(i);
            #0.1;
            chk("R7 saved zero", saved_rd, 32'd0);
        end

        // R1 R2 R3 R5: live writes, every bank x every mask
        for (int b = 0; b < 8; b++) begin
            for (int m = 0; m < 16; m++) begin
                logic [31:0] nw;
                nw = merge(m_psw, pat(b, m), 4'(m), (b == 0));
                do_wr(1'b0, 3'(b), 4'(m), pat(b, m));
                chk(b == 0 ? "R1 user live write" : (m == 9 ? "R2 full write" : "R3 field write"),
                    psw, nw);
                chk("R5 mode_chg", {31'd0, mode_chg}, {31'd0, nw[4:0] != m_psw[4:0]});
                m_psw = nw;
            end
        end
        @(negedge clk);
        chk("R5 strobe one cycle", {31'd0, mode_chg}, 32'd0);

        // R4 R8: saved writes, every bank x every mask
        for (int b = 0; b < 8; b++) begin
            for (int m = 0; m < 16; m++) begin
                logic [31:0] d;
                d = ~pat(m, b);
                if (b >= 1 && b <= 5) m_saved[b] = merge(m_saved[b], d, 4'(m), 1'b0);
                do_wr(1'b1, 3'(b), 4'(m), d);
                rd_bank = 3'(b);
                #0.1;
                chk("R4 saved write/read", saved_rd, m_saved[b]);
                chk("R8 live kept on saved write", psw, m_psw);
                chk("R5 no chg on saved write", {31'd0, mode_chg}, 32'd0);
            end
        end
        for (int i = 0; i < 8; i++) begin
            rd_bank = 3'(i);
            #0.1;
            chk("R4 readback all banks", saved_rd, m_saved[i]);
        end
        // R8: live write leaves saved words alone
        do_wr(1'b0, 3'd3, 4'd9, 32'hF0F0_0013);
        m_psw = 32'hF0F0_0013;
        for (int i = 0; i < 8; i++) begin
            rd_bank = 3'(i);
            #0.1;
            chk("R8 saved kept on live write", saved_rd, m_saved[i]);
        end

        // R6: exception priority under each mask state
        for (int fm = 0; fm < 4; fm++) begin
            logic [31:0] d;
            d = {24'h0, 2'(fm >> 1), 1'(fm), 5'h13};
            d[7] = fm[1]; d[6] = fm[0];
            do_wr(1'b0, 3'd3, 4'd9, d);
            chk("R2 mask setup", psw, d);
            for (int l = 0; l < 8; l++) begin
                nrst_line = l[0]; nfiq_line = l[1]; nirq_line = l[2];
                @(negedge clk);
                chk("R6 exc_sel", {29'd0, exc_sel}, {29'd0, exp_exc(3'(l), 2'(fm))});
                nrst_line = 1'b1; nfiq_line = 1'b1; nirq_line = 1'b1;
                @(negedge clk);
                chk("R6 exc idle", {29'd0, exc_sel}, 32'd0);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule